// File: doc/BRIEF.md
# USB Device Bus Event Flag Register

This block holds the eight-bit interrupt flag register of a USB device controller. Five single-cycle event pulses from the protocol engine each set their own sticky flag: start-of-frame received, bus reset seen, STALL handshake returned, IN transaction with nothing to send, and OUT transaction that could not be accepted. Software reads the register through a small register port. It clears any flag by writing a one to that flag's bit.

The block also watches a bus-idle indicator with a cycle counter. When the bus has been idle for a programmable number of clock cycles (the 3 ms suspend interval), it raises a suspend flag once and enters a suspended state. The first non-idle cycle after that leaves the suspended state and raises a resume flag. This works for a resume that the host starts and for one the device starts. A registered interrupt output is high whenever any flag is set.

Top module: `usb_evflag_top`

## Requirements
- R1: After reset, every flag is 0, `irq` is 0, and a read of the register returns 0x00.
- R2: Each event pulse sets its own flag on the clock edge that samples it. The bit positions are: start-of-frame bit 7, bus reset bit 4, STALL bit 3, IN underflow bit 2, OUT overflow bit 1.
- R3: A write to address `FLAG_ADDR` (default 0x09) clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. A write to any other address changes no flag.
- R4: A set flag stays set, with or without further events, until software clears it.
- R5: The suspend flag (bit 6) is set on the `IDLE_CYCLES`-th consecutive clock edge that samples `bus_idle` high. Any edge that samples `bus_idle` low restarts the count.
- R6: The suspend flag is raised only once per idle period. After software clears it, continued idleness does not set it again.
- R7: The resume flag (bit 5) is set on the first edge that samples `bus_idle` low while the block is suspended. A non-idle bus when the block is not suspended does not set it.
- R8: If an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: Bit 0 always reads as 0, and writes to it have no effect.
- R10: `irq` equals the OR of all flags, delayed by one clock cycle.
- R11: A read with `reg_rd` high returns the flag byte on `reg_rdata` after the next edge, as the flags stood before that edge. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idle | input | 1 | High while the bus is in the idle state |
| ev_sof | input | 1 | Start-of-frame received pulse |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_stall | input | 1 | STALL handshake sent pulse |
| ev_in_underflow | input | 1 | IN transaction had no data pulse |
| ev_out_overflow | input | 1 | OUT transaction could not be accepted pulse |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; ones clear flags |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered OR of all flags |

## Verification
The properties assume that every event input is a clean synchronous level sampled once per edge and that `bus_idle` changes only between edges. They also assume that reads and writes are single-cycle strobes at a stable address. The stimulus drives all inputs on the falling clock edge and holds them for exactly one rising edge per operation. It runs the idle counter with a short `IDLE_CYCLES` override, so the suspend count, the restart after a non-idle cycle and the resume edge can each be reached a known number of edges after the change in `bus_idle`.

// File: rtl/usb_evflag_pkg.sv
package usb_evflag_pkg;
  localparam int FLAG_W   = 8;
  // Bit positions are decoded by software and must stay fixed.
  localparam int B_SOF    = 7;
  localparam int B_SUSP   = 6;
  localparam int B_RESUME = 5;
  localparam int B_BUSRST = 4;
  localparam int B_STALL  = 3;
  localparam int B_UNF    = 2;
  localparam int B_OVF    = 1;
  localparam int B_RSVD   = 0;

  localparam logic [FLAG_W-1:0] LIVE_MASK = ~(FLAG_W'(1) << B_RSVD);

  function automatic logic [FLAG_W-1:0] pack_sets(
    input logic sof, input logic susp, input logic resume, input logic busrst,
    input logic stall, input logic unf, input logic ovf);
    logic [FLAG_W-1:0] v;
    v           = '0;
    v[B_SOF]    = sof;
    v[B_SUSP]   = susp;
    v[B_RESUME] = resume;
    v[B_BUSRST] = busrst;
    v[B_STALL]  = stall;
    v[B_UNF]    = unf;
    v[B_OVF]    = ovf;
    return v;
  endfunction
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE_CYCLES = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  output logic suspend_hit,
  output logic resume_hit,
  output logic suspended
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

  logic [CNT_W-1:0] idle_cnt;

  // idle_cnt holds the number of idle samples already seen; the next one is the Nth.
  assign suspend_hit = bus_idle && !suspended && (idle_cnt == LAST);
  assign resume_hit  = !bus_idle && suspended;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt  <= '0;
      suspended <= 1'b0;
    end else if (!bus_idle) begin
      idle_cnt  <= '0;
      suspended <= 1'b0;
    end else if (!suspended) begin
      if (suspend_hit) suspended <= 1'b1;
      else             idle_cnt  <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)             flags[i] <= 1'b0;
        else if (set_vec[i]) flags[i] <= 1'b1;   // set beats clear
        else if (clr_vec[i]) flags[i] <= 1'b0;
      end
    end else begin : g_tied
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_evflag_top.sv
module usb_evflag_top
  import usb_evflag_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FLAG_ADDR   = 9,
  parameter int IDLE_CYCLES = 144000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_idle,
  input  logic              ev_sof,
  input  logic              ev_bus_reset,
  input  logic              ev_stall,
  input  logic              ev_in_underflow,
  input  logic              ev_out_overflow,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(FLAG_ADDR);

  logic              susp_hit, res_hit, tmr_susp;
  logic [FLAG_W-1:0] set_vec, clr_vec, flag_q;
  logic              sel;

  usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .bus_idle(bus_idle),
    .suspend_hit(susp_hit), .resume_hit(res_hit), .suspended(tmr_susp)
  );

  assign sel     = (reg_addr == SEL);
  assign set_vec = pack_sets(ev_sof, susp_hit, res_hit, ev_bus_reset,
                             ev_stall, ev_in_underflow, ev_out_overflow);
  assign clr_vec = (reg_wr && sel) ? reg_wdata : '0;

  usb_flag_bank #(.W(FLAG_W), .MASK(LIVE_MASK)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= |flag_q;
      if (reg_rd) reg_rdata <= sel ? flag_q : '0;
    end
  end
endmodule

// File: rtl/usb_evflag_chk.sv
module usb_evflag_chk #(
  parameter int ADDR_W    = 8,
  parameter int FLAG_ADDR = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_idle,
  input logic              ev_sof,
  input logic              ev_out_overflow,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        flags,
  input logic              suspended,
  input logic              irq
);
  logic wr_hit;
  assign wr_hit = reg_wr && (reg_addr == ADDR_W'(FLAG_ADDR));

  a_r2_sof_sets: assert property (@(posedge clk) disable iff (rst)
    ev_sof |=> flags[7]);

  a_r3_clear_ovf: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && reg_wdata[1] && !ev_out_overflow) |=> !flags[1]);

  a_r4_sticky_sof: assert property (@(posedge clk) disable iff (rst)
    (flags[7] && !(wr_hit && reg_wdata[7])) |=> flags[7]);

  a_r7_resume_on_wake: assert property (@(posedge clk) disable iff (rst)
    (suspended && !bus_idle) |=> (flags[5] && !suspended));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_out_overflow && wr_hit && reg_wdata[1]) |=> flags[1]);

  a_r9_bit0_zero: assert property (@(posedge clk) disable iff (rst)
    !flags[0]);

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|flags)));
endmodule

bind usb_evflag_top usb_evflag_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_idle(bus_idle), .ev_sof(ev_sof),
  .ev_out_overflow(ev_out_overflow), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .flags(flag_q), .suspended(tmr_susp), .irq(irq)
);

// File: tb/usb_evflag_top_test.sv
module usb_evflag_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 20;
  localparam logic [7:0] REG = 8'h09;

  logic clk = 1'b0, rst = 1'b1, bus_idle = 1'b0;
  logic ev_sof = 0, ev_bus_reset = 0, ev_stall = 0, ev_in_underflow = 0, ev_out_overflow = 0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic reg_wr = 0, reg_rd = 0, irq;
  int tests = 0, fails = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_evflag_top #(.ADDR_W(8), .FLAG_ADDR(9), .IDLE_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .ev_sof(ev_sof),
    .ev_bus_reset(ev_bus_reset), .ev_stall(ev_stall),
    .ev_in_underflow(ev_in_underflow), .ev_out_overflow(ev_out_overflow),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Fields: events {sof,busrst,stall,unf,ovf}, write enable, write data, expected flags.
  localparam logic [21:0] VEC [10] = '{
    {5'b10000, 1'b0, 8'h00, 8'h80},   // R2 sof -> bit 7
    {5'b00100, 1'b0, 8'h00, 8'h88},   // R2 stall -> bit 3, R4 sof held
    {5'b00000, 1'b1, 8'h08, 8'h80},   // R3 clear only bit 3
    {5'b00011, 1'b0, 8'h00, 8'h86},   // R2 unf bit 2, ovf bit 1
    {5'b01000, 1'b0, 8'h00, 8'h96},   // R2 bus reset bit 4
    {5'b00000, 1'b1, 8'hFF, 8'h00},   // R3 clear all
    {5'b00001, 1'b1, 8'h02, 8'h02},   // R8 set wins over clear
    {5'b00000, 1'b1, 8'h01, 8'h02},   // R9 bit 0 write ignored
    {5'b00000, 1'b1, 8'h00, 8'h02},   // R3 zero data leaves flags
    {5'b00000, 1'b1, 8'h02, 8'h00}    // R3 clear ovf
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(REG, rv); check("R1 flags after reset", rv, 8'h00);

    foreach (VEC[i]) begin
      {ev_sof, ev_bus_reset, ev_stall, ev_in_underflow, ev_out_overflow} = VEC[i][21:17];
      reg_wr = VEC[i][16]; reg_wdata = VEC[i][15:8]; reg_addr = REG;
      @(negedge clk);
      {ev_sof, ev_bus_reset, ev_stall, ev_in_underflow, ev_out_overflow} = 5'b0;
      reg_wr = 1'b0; reg_wdata = 8'h00;
      rd(REG, rv); check($sformatf("R2/R3/R8/R9 vector %0d", i), rv, VEC[i][7:0]);
    end

    // R10 irq one cycle after the flag
    ev_stall = 1'b1; @(negedge clk); ev_stall = 1'b0;
    check("R10 irq not yet", {7'd0, irq}, 8'h00);
    tick(1);
    check("R10 irq high", {7'd0, irq}, 8'h01);
    // R3 write to another address has no effect; R11 foreign read returns 0
    wr(8'h0A, 8'hFF);
    rd(REG, rv); check("R3 foreign address write", rv, 8'h08);
    rd(8'h0A, rv); check("R11 foreign address read", rv, 8'h00);
    wr(REG, 8'h08); tick(1);
    check("R10 irq low after clear", {7'd0, irq}, 8'h00);

    // R5 suspend on Nth idle edge
    bus_idle = 1'b1; tick(N-1);
    rd(REG, rv); check("R5 suspend not before N", rv, 8'h00);
    rd(REG, rv); check("R5 suspend at N", rv, 8'h40);
    // R6 no re-raise while still idle
    wr(REG, 8'h40); tick(10);
    rd(REG, rv); check("R6 suspend once per period", rv, 8'h00);
    // R7 resume on first non-idle edge
    bus_idle = 1'b0; tick(1);
    rd(REG, rv); check("R7 resume set", rv, 8'h20);
    wr(REG, 8'h20); tick(3);
    rd(REG, rv); check("R7 no resume when awake", rv, 8'h00);

    // R5 restart: N-2 idle, 1 busy, then N-1 idle
    bus_idle = 1'b1; tick(N-2);
    bus_idle = 1'b0; tick(1);
    bus_idle = 1'b1; tick(N-2);
    rd(REG, rv); check("R5 counter restarted", rv, 8'h00);
    rd(REG, rv); check("R5 suspend after restart pending", rv, 8'h00);
    rd(REG, rv); check("R5 suspend after restart", rv, 8'h40);

    // R1 reset clears everything
    rst = 1'b1; tick(1); rst = 1'b0; bus_idle = 1'b0;
    rd(REG, rv); check("R1 reset clears flags", rv, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule